// File: doc/BRIEF.md
# Background Memory CRC Integrity Checker

This block checks a fixed-size configuration memory for corruption while the chip runs. It walks the memory one 32-bit word at a time through a read-only port and folds each word into a 32-bit CRC. When it reaches the last address it wraps back to address zero and starts again. The signature from the first complete walk after reset becomes the reference. Each later walk produces a fresh signature, which is compared with that reference at the end of the walk. A difference sets a sticky error flag, which can drive a reconfiguration request. Scanning continues after an error.

The scan pace comes from a programmable divider. One word is read for every `div_value + 1` enabled clock cycles, so the divider trades detection latency against memory read activity. A new divider value takes effect only when the next walk begins. Dropping `enable` freezes the scan in place: the address, the partial CRC and the divider phase all hold. Raising `enable` again resumes the scan from the same point.

A controller with three states sequences the scan. `ST_IDLE` is the state after reset. The transition START (`enable` high) moves it to `ST_REF`. `ST_REF` walks the reference pass, and the transition REF_DONE (the tick that reads the last word) moves it to `ST_CHECK`. `ST_CHECK` walks every later pass and stays in `ST_CHECK` through each wrap. No transition leaves `ST_REF` or `ST_CHECK` except reset.

Top module: `bg_crc_scrubber`

## Requirements
- R1: The signature of a pass is the CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. It is non-reflected with no final inversion. It covers addresses 0 up to DEPTH-1 in order, and within each word bits 31 down to 0 in turn. It appears on `sig_out` in the cycle that `pass_done` is high, and it holds until the next pass ends.
- R2: The first pass after reset is taken as the reference, and it never sets `crc_error`, whatever the memory holds.
- R3: Every later pass is compared with the reference. A mismatch sets `crc_error` in the same cycle that `pass_done` pulses for that pass.
- R4: `crc_error` stays high until a synchronous `err_clear` or reset. If a mismatch and `err_clear` arrive in the same cycle, the set wins. Scanning and `pass_done` pulses continue while the error is high.
- R5: One word is read per tick, and a tick comes every `div_value + 1` enabled clock cycles. A pass therefore spans DEPTH*(div_value+1) cycles from one `pass_done` pulse to the next, and `mem_addr` only ever steps by +1 with wrap-around.
- R6: The divider value is sampled only when a pass starts. A change made during a pass leaves that pass's length unchanged and applies from the following pass.
- R7: While `enable` is low, `mem_addr` holds and the scan does not progress. The pass in progress grows by exactly the number of disabled cycles, and its signature is unaffected.
- R8: After reset `crc_error`, `pass_done`, `mem_addr` and `sig_out` are all zero. With `enable` low the block stays idle and gives no `pass_done`.
- R9: A pass whose signature matches the reference leaves a cleared `crc_error` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Scan enable; low freezes the scan |
| div_value | input | DIV_W | Tick divider: one word per div_value+1 cycles |
| err_clear | input | 1 | Synchronous clear of the sticky error |
| mem_addr | output | ADDR_W | Read address into the protected memory |
| mem_rdata | input | 32 | Word at mem_addr (combinational read) |
| pass_done | output | 1 | One-cycle pulse at the end of each pass |
| sig_out | output | 32 | Signature of the most recent pass |
| crc_error | output | 1 | Sticky mismatch flag |

## Verification
The bench sweeps every divider value of a small configuration. It changes the divider both at pass boundaries and during a pass. This separates a divider sampled once per pass from one that is applied at once. It then flips every single bit of every memory word in turn. Each flip must set the error and give the arithmetically computed signature, and restoring the word must give a clean pass. This shows that every bit position and address reaches the CRC and that the comparison is against the stored reference. Separate sequences cover a long disable inside a pass, a clear held high across a mismatching pass end, and a corrupt memory that is left in place. These tell apart a true freeze from a restart, set priority from clear priority, and stickiness from a simple per-pass flag.

// File: rtl/crc_scrub_pkg.sv
package crc_scrub_pkg;

    localparam int WORD_W = 32;
    localparam logic [WORD_W-1:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [WORD_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REF   = 2'd1,
        ST_CHECK = 2'd2
    } scan_state_t;

    // Fold one word into the running CRC, most significant data bit first.
    function automatic logic [WORD_W-1:0] crc_fold_word(
        input logic [WORD_W-1:0] crc_in,
        input logic [WORD_W-1:0] word
    );
        logic [WORD_W-1:0] acc;
        acc = crc_in;
        for (int b = WORD_W - 1; b >= 0; b--) begin
            if (acc[WORD_W-1] ^ word[b]) begin
                acc = {acc[WORD_W-2:0], 1'b0} ^ CRC_POLY;
            end else begin
                acc = {acc[WORD_W-2:0], 1'b0};
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/crc_scrub_tick.sv
module crc_scrub_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);

    logic [DIV_W-1:0] div_act_q;
    logic [DIV_W-1:0] phase_q;

    assign tick = run && (phase_q == div_act_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_act_q <= '0;
            phase_q   <= '0;
        end else if (load) begin
            div_act_q <= div_in;
            phase_q   <= '0;
        end else if (run) begin
            if (tick) begin
                phase_q <= '0;
            end else begin
                phase_q <= phase_q + 1'b1;
            end
        end
    end

    // R5: the phase counter never runs past the latched divider value
    a_r5_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= div_act_q);

    // R7: with run low and no load, the phase holds
    a_r7_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(phase_q));

    // R6: the latched divider only moves on a load
    a_r6_div_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(div_act_q));

endmodule

// File: rtl/crc_scrub_engine.sv
module crc_scrub_engine
    import crc_scrub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              last,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] crc_next
);

    logic [WORD_W-1:0] crc_q;

    assign crc_next = crc_fold_word(crc_q, word);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (step) begin
            if (last) begin
                crc_q <= CRC_SEED;
            end else begin
                crc_q <= crc_next;
            end
        end
    end

    // R7: the partial CRC holds whenever no word is consumed
    a_r7_crc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(crc_q));

endmodule

// File: rtl/crc_scrub_judge.sv
module crc_scrub_judge
    import crc_scrub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close,
    input  logic              capture,
    input  logic [WORD_W-1:0] final_crc,
    input  logic              err_clear,
    output logic              pass_done,
    output logic [WORD_W-1:0] sig_out,
    output logic              crc_error
);

    logic [WORD_W-1:0] ref_q;
    logic              mismatch;

    assign mismatch = close && !capture && (final_crc != ref_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_q     <= '0;
            sig_out   <= '0;
            pass_done <= 1'b0;
            crc_error <= 1'b0;
        end else begin
            pass_done <= close;
            if (close) begin
                sig_out <= final_crc;
            end
            if (capture) begin
                ref_q <= final_crc;
            end
            if (mismatch) begin
                crc_error <= 1'b1;
            end else if (err_clear) begin
                crc_error <= 1'b0;
            end
        end
    end

    // R4: error stays high unless cleared
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (crc_error && !err_clear) |=> crc_error);

    // R2: the reference pass never raises the error
    a_r2_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !crc_error) |=> !crc_error);

    // R3: the error can only rise together with a pass_done pulse
    a_r3_rise_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_error) |-> pass_done);

    // R1: the signature only changes at a pass end
    a_r1_sig_held: assert property (@(posedge clk) disable iff (!rst_n)
        !close |=> $stable(sig_out));

endmodule

// File: rtl/bg_crc_scrubber.sv
module bg_crc_scrubber
    import crc_scrub_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_value,
    input  logic              err_clear,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              pass_done,
    output logic [WORD_W-1:0] sig_out,
    output logic              crc_error
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = '1;

    scan_state_t       state_q;
    scan_state_t       state_d;
    logic [ADDR_W-1:0] addr_q;

    logic              tick;
    logic              run;
    logic              start;
    logic              at_last;
    logic              wrap;
    logic              capture;
    logic              div_load;
    logic [WORD_W-1:0] crc_next;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: START, REF_DONE, and the CHECK self-loop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (enable) state_d = ST_REF;
            ST_REF:   if (wrap)   state_d = ST_CHECK;
            ST_CHECK: state_d = ST_CHECK;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        run     = 1'b0;
        start   = 1'b0;
        capture = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start = enable;
            end
            ST_REF: begin
                run     = enable;
                capture = wrap;
            end
            ST_CHECK: begin
                run = enable;
            end
            default: begin
                run = 1'b0;
            end
        endcase
    end

    assign at_last  = (addr_q == LAST_ADDR);
    assign wrap     = tick && at_last;
    assign div_load = start || wrap;
    assign mem_addr = addr_q;

    // Address counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (tick) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    crc_scrub_tick #(
        .DIV_W (DIV_W)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .load   (div_load),
        .div_in (div_value),
        .tick   (tick)
    );

    crc_scrub_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (tick),
        .last     (at_last),
        .word     (mem_rdata),
        .crc_next (crc_next)
    );

    crc_scrub_judge u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .close     (wrap),
        .capture   (capture),
        .final_crc (crc_next),
        .err_clear (err_clear),
        .pass_done (pass_done),
        .sig_out   (sig_out),
        .crc_error (crc_error)
    );

    // R7: address holds while the scan is disabled
    a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(mem_addr));

    // R5: the address only ever steps by one, wrapping
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (mem_addr == ($past(mem_addr) + 1'b1)));

    // R2: once checking, the controller never returns to reference capture
    a_r2_check_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK) |=> (state_q == ST_CHECK));

    // R5: pass_done is a single-cycle pulse
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pass_done |=> !pass_done);

    // R8: idle with enable low gives no pass end
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !pass_done);

endmodule

// File: tb/bg_crc_scrubber_bench.sv
`timescale 1ns/1ps
module bg_crc_scrubber_bench;

    localparam int AW    = 3;
    localparam int DW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam logic [31:0] POLY = 32'h04C11DB7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [DW-1:0] div_value = '0;
    logic          err_clear = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_rdata;
    logic          pass_done;
    logic [31:0]   sig_out;
    logic          crc_error;

    logic [31:0] mem [DEPTH];
    logic [31:0] golden;

    int total = 0;
    int failed = 0;
    int cyc = 0;
    int prev_done = 0;
    int interval = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign mem_rdata = mem[mem_addr];

    bg_crc_scrubber #(.ADDR_W(AW), .DIV_W(DW)) u_bg_crc_scrubber (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div_value(div_value),
        .err_clear(err_clear), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .pass_done(pass_done), .sig_out(sig_out), .crc_error(crc_error)
    );

    function automatic logic [31:0] expect_sig();
        logic [31:0] c;
        c = 32'hFFFFFFFF;
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 31; b >= 0; b--) begin
                if (c[31] ^ mem[a][b]) c = (c << 1) ^ POLY;
                else c = c << 1;
            end
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pass_done && n < 5000);
        if (!pass_done) begin
            chk(1'b0, "R5", "pass_done timeout", 32'(n), 32'd0);
        end
        interval  = cyc - prev_done;
        prev_done = cyc;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        total++;
        failed++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = (a * 32'h9E3779B9) ^ 32'h5A5A0F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(crc_error == 1'b0, "R8", "error after reset", 32'(crc_error), 0);
        chk(pass_done == 1'b0, "R8", "done after reset", 32'(pass_done), 0);
        chk(mem_addr == '0, "R8", "addr after reset", 32'(mem_addr), 0);
        chk(sig_out == '0, "R8", "sig after reset", sig_out, 0);
        begin
            bit seen;
            seen = 1'b0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (pass_done || mem_addr != '0) seen = 1'b1;
            end
            chk(!seen, "R8", "activity while idle", 32'(seen), 0);
        end

        // R1/R2: reference pass, then a matching pass
        golden = expect_sig();
        enable = 1'b1;
        wait_done();
        chk(sig_out == golden, "R1", "reference signature", sig_out, golden);
        chk(crc_error == 1'b0, "R2", "error on reference pass", 32'(crc_error), 0);
        wait_done();
        chk(sig_out == golden, "R1", "second signature", sig_out, golden);
        chk(interval == DEPTH, "R5", "pass length div 0", 32'(interval), DEPTH);
        chk(crc_error == 1'b0, "R9", "error on matching pass", 32'(crc_error), 0);

        // R5/R6: full divider sweep, changed at pass boundaries
        begin
            int prev;
            prev = 0;
            for (int d = 0; d < (1 << DW); d++) begin
                div_value = DW'(d);
                wait_done();
                chk(interval == DEPTH * (prev + 1), "R6", "old divider kept",
                    32'(interval), 32'(DEPTH * (prev + 1)));
                wait_done();
                chk(interval == DEPTH * (d + 1), "R5", "divider pass length",
                    32'(interval), 32'(DEPTH * (d + 1)));
                chk(sig_out == golden, "R1", "signature at divider", sig_out, golden);
                prev = d;
            end
        end

        // R6: change mid-pass (currently div 15)
        repeat (20) @(negedge clk);
        div_value = 4'd2;
        wait_done();
        chk(interval == DEPTH * 16, "R6", "mid-pass change ignored", 32'(interval), DEPTH * 16);
        wait_done();
        chk(interval == DEPTH * 3, "R6", "mid-pass change applied", 32'(interval), DEPTH * 3);

        // R7: freeze inside a pass
        repeat (5) @(negedge clk);
        begin
            logic [AW-1:0] held;
            bit moved;
            held  = mem_addr;
            moved = 1'b0;
            enable = 1'b0;
            for (int i = 0; i < 7; i++) begin
                @(negedge clk);
                if (mem_addr != held || pass_done) moved = 1'b1;
            end
            chk(!moved, "R7", "scan moved while disabled", 32'(moved), 0);
            enable = 1'b1;
        end
        wait_done();
        chk(interval == DEPTH * 3 + 7, "R7", "pass stretched by freeze",
            32'(interval), DEPTH * 3 + 7);
        chk(sig_out == golden, "R7", "signature after freeze", sig_out, golden);

        // back to div 0
        div_value = '0;
        wait_done();
        wait_done();

        // R4: clear held across a mismatching pass end; set wins
        mem[3] = mem[3] ^ 32'h0000_0100;
        err_clear = 1'b1;
        wait_done();
        err_clear = 1'b0;
        chk(crc_error == 1'b1, "R4", "set wins over clear", 32'(crc_error), 1);
        wait_done();
        chk(crc_error == 1'b1, "R4", "error still set", 32'(crc_error), 1);
        mem[3] = mem[3] ^ 32'h0000_0100;
        wait_done();
        chk(crc_error == 1'b1, "R4", "sticky over clean pass", 32'(crc_error), 1);
        chk(sig_out == golden, "R4", "scan continues", sig_out, golden);
        err_clear = 1'b1;
        @(negedge clk);
        err_clear = 1'b0;
        chk(crc_error == 1'b0, "R4", "clear", 32'(crc_error), 0);
        wait_done();
        chk(crc_error == 1'b0, "R9", "clean after clear", 32'(crc_error), 0);

        // R3: every single-bit flip in every word
        for (int a = 0; a < DEPTH; a++) begin
            for (int b = 0; b < 32; b++) begin
                logic [31:0] bad;
                mem[a][b] = ~mem[a][b];
                bad = expect_sig();
                wait_done();
                chk(crc_error == 1'b1, "R3", "flip detected", 32'(crc_error), 1);
                chk(sig_out == bad, "R1", "corrupt signature", sig_out, bad);
                mem[a][b] = ~mem[a][b];
                err_clear = 1'b1;
                @(negedge clk);
                err_clear = 1'b0;
                chk(crc_error == 1'b0, "R4", "clear after flip", 32'(crc_error), 0);
                wait_done();
                chk(crc_error == 1'b0, "R9", "restored pass clean", 32'(crc_error), 0);
                chk(sig_out == golden, "R1", "restored signature", sig_out, golden);
            end
        end

        finish_run();
    end

endmodule